// File: doc/BRIEF.md
# Write-Only I2C Register File for a Three-Channel LED Engine

This block is the host-facing register file of a three-channel LED engine. It watches a two-wire I2C bus through an oversampling system clock, answers only to write transfers aimed at its own 7-bit device address, and stores the received bytes into a small register map. Two of the seven address bits come from an address-select input, so up to four engines can share one bus.

After the device address, the host sends one byte that loads an internal register pointer, then any number of data bytes. Each data byte lands at the pointer, and the pointer then moves on by one, so a burst fills consecutive registers. The global control registers take a new value as soon as their byte is received. Per-channel brightness, the channel-enable mask and all timing registers are written into shadow copies. The engine does not see a shadow copy until the host writes any value to the matching commit register. One commit register covers brightness and enables, and a separate one covers timing. A write of any value to the reset register returns every shadow and live register to its power-on value.

Top module: `led_i2c_regfile`

## Requirements
- R1: The device address byte is `1101_0`, then `addr_sel_i[1:0]`, then a direction bit of 0 (bits 7..0, MSB first). Only this exact byte is acknowledged. A byte that differs, including one with the direction bit set, gets no acknowledge, and the block leaves the bus alone until the next START.
- R2: Bits are shifted in MSB first on each SCL rising edge. After a matching address byte, after the pointer byte and after every data byte, the block pulls SDA low for the ninth clock (`sda_oe_o` = 1). It releases SDA at the SCL falling edge that ends that clock.
- R3: Each data byte is stored at the current pointer, and the pointer then advances by one. Successive bytes of a burst therefore fill successive addresses.
- R4: Data bytes for brightness (04h, 05h, 06h for channels 0 to 2) and for the enable mask (1Dh, bit n enables channel n) go to shadow copies. A write of any value to 07h copies all four shadows into the live outputs in one cycle. Until then the live outputs keep their values.
- R5: Data bytes for the timing registers (delay 0Ah–0Ch, rise/hold 10h–12h, fall/off 16h–18h, each ordered channel 0 to 2) go to shadow copies. A write of any value to 1Ch commits all nine at once.
- R6: Power-on values are control 00h = 01h and enable mask 1Dh = 07h, shadow and live. Every other register is 00h. A write of any value to 2Fh restores all of these.
- R7: Registers 00h (control), 01h (breathing control: ramp bit 5, hold select bit 4, mark enable bit 2, marked channel bits 1:0), 02h (mode, bit 5 = 1 for pattern mode) and 03h (current level) take effect on the data byte itself.
- R8: A data byte sent to an unmapped address is acknowledged and discarded, and the pointer still advances.
- R9: A STOP (SDA rising while SCL is high) releases SDA and returns the receiver to idle. A START (SDA falling while SCL is high) at any point, even in the middle of a byte, restarts reception with a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| addr_sel_i | input | 2 | Address-select bits placed in device-address bits 2:1 |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| ctrl_o | output | 8 | Live control register 00h |
| breath_o | output | 8 | Live breathing control register 01h |
| mode_o | output | 8 | Live mode register 02h |
| cur_o | output | 8 | Live current level register 03h |
| duty_o | output | 24 | Live brightness, channel n in bits 8n+7:8n |
| chen_o | output | 8 | Live channel enable mask |
| tdly_o | output | 24 | Live delay timing per channel |
| trise_o | output | 24 | Live rise/hold timing per channel |
| tfall_o | output | 24 | Live fall/off timing per channel |

## Verification
The assertions check on every cycle how the acknowledge is timed and released: it may start only after a sampled SCL falling edge, and it must drop after a STOP. They also check that the pointer steps by one on each stored byte. At the register map, they check that live brightness never moves except on a commit or reset, that a commit copies the shadows exactly, and that the reset register brings back the power-on values. Only the bench scenarios can show behaviour that spans whole transfers. These cover address filtering against the select pins, ignoring of the bus after a mismatch, a START that cuts into a byte, bursts that run across unmapped addresses, and the split between the two commit groups.

// File: rtl/led_i2c_pkg.sv
package led_i2c_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SKIP
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_PTR,
        PH_DATA
    } byte_phase_e;

    localparam logic [4:0] DEV_PREFIX = 5'b11010;

    localparam logic [7:0] A_CTRL     = 8'h00;
    localparam logic [7:0] A_BREATH   = 8'h01;
    localparam logic [7:0] A_MODE     = 8'h02;
    localparam logic [7:0] A_CUR      = 8'h03;
    localparam logic [7:0] A_DUTY0    = 8'h04;
    localparam logic [7:0] A_UPD_LED  = 8'h07;
    localparam logic [7:0] A_TDLY0    = 8'h0A;
    localparam logic [7:0] A_TRISE0   = 8'h10;
    localparam logic [7:0] A_TFALL0   = 8'h16;
    localparam logic [7:0] A_UPD_TIME = 8'h1C;
    localparam logic [7:0] A_CHEN     = 8'h1D;
    localparam logic [7:0] A_RESET    = 8'h2F;

    localparam logic [7:0] CTRL_DEFAULT = 8'h01;
    localparam logic [7:0] CHEN_DEFAULT = 8'h07;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sync;
        logic [SYNC_STAGES-1:0] sda_sync;
        logic                   scl_prev;
        logic                   sda_prev;
    } samp_t;

    samp_t samp_d, samp_q;

    always_comb begin
        samp_d          = samp_q;
        samp_d.scl_sync = {samp_q.scl_sync[SYNC_STAGES-2:0], scl_i};
        samp_d.sda_sync = {samp_q.sda_sync[SYNC_STAGES-2:0], sda_i};
        samp_d.scl_prev = samp_q.scl_sync[LAST];
        samp_d.sda_prev = samp_q.sda_sync[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) samp_q <= '1;
        else        samp_q <= samp_d;
    end

    logic scl_now, sda_now;
    assign scl_now    = samp_q.scl_sync[LAST];
    assign sda_now    = samp_q.sda_sync[LAST];
    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~samp_q.scl_prev;
    assign scl_fall_o = ~scl_now & samp_q.scl_prev;
    assign start_o    = scl_now & samp_q.scl_prev & samp_q.sda_prev & ~sda_now;
    assign stop_o     = scl_now & samp_q.scl_prev & ~samp_q.sda_prev & sda_now;

endmodule

// File: rtl/i2c_write_engine.sv
module i2c_write_engine
    import led_i2c_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [SEL_W-1:0] addr_sel_i,
    output logic             sda_oe_o,
    output logic             wr_stb_o,
    output logic [7:0]       wr_addr_o,
    output logic [7:0]       wr_data_o
);

    localparam int         CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    typedef struct packed {
        bus_state_e        state;
        byte_phase_e       phase;
        logic [CNT_W-1:0]  bitcnt;
        logic [7:0]        shreg;
        logic [7:0]        ptr;
        logic              ack;
        logic              wr_stb;
        logic [7:0]        wr_addr;
        logic [7:0]        wr_data;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [7:0] own_addr;

    assign own_addr = {DEV_PREFIX, addr_sel_i, 1'b0};

    always_comb begin
        eng_d        = eng_q;
        eng_d.wr_stb = 1'b0;
        if (start_i) begin
            eng_d.state  = ST_RECV;
            eng_d.phase  = PH_DEV;
            eng_d.bitcnt = '0;
            eng_d.ack    = 1'b0;
        end else if (stop_i) begin
            eng_d.state = ST_IDLE;
            eng_d.ack   = 1'b0;
        end else begin
            case (eng_q.state)
                ST_RECV: begin
                    if (scl_rise_i && eng_q.bitcnt < FULL_CNT) begin
                        eng_d.shreg  = {eng_q.shreg[6:0], sda_i};
                        eng_d.bitcnt = eng_q.bitcnt + 1'b1;
                    end else if (scl_fall_i && eng_q.bitcnt == FULL_CNT) begin
                        case (eng_q.phase)
                            PH_DEV: begin
                                if (eng_q.shreg == own_addr) begin
                                    eng_d.ack   = 1'b1;
                                    eng_d.state = ST_ACK;
                                end else begin
                                    eng_d.state = ST_SKIP;
                                end
                            end
                            PH_PTR: begin
                                eng_d.ptr   = eng_q.shreg;
                                eng_d.ack   = 1'b1;
                                eng_d.state = ST_ACK;
                            end
                            default: begin
                                eng_d.wr_stb  = 1'b1;
                                eng_d.wr_addr = eng_q.ptr;
                                eng_d.wr_data = eng_q.shreg;
                                eng_d.ptr     = eng_q.ptr + 8'd1;
                                eng_d.ack     = 1'b1;
                                eng_d.state   = ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        eng_d.ack    = 1'b0;
                        eng_d.state  = ST_RECV;
                        eng_d.bitcnt = '0;
                        eng_d.phase  = (eng_q.phase == PH_DEV) ? PH_PTR : PH_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q       <= '0;
            eng_q.state <= ST_IDLE;
            eng_q.phase <= PH_DEV;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sda_oe_o  = eng_q.ack;
    assign wr_stb_o  = eng_q.wr_stb;
    assign wr_addr_o = eng_q.wr_addr;
    assign wr_data_o = eng_q.wr_data;

    // R2
    ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_q.ack) |-> $past(scl_fall_i));

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !sda_oe_o);

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.wr_stb |-> (eng_q.ptr == eng_q.wr_addr + 8'd1));

endmodule

// File: rtl/led_reg_bank.sv
module led_reg_bank
    import led_i2c_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [7:0]       addr_i,
    input  logic [7:0]       data_i,
    output logic [7:0]       ctrl_o,
    output logic [7:0]       breath_o,
    output logic [7:0]       mode_o,
    output logic [7:0]       cur_o,
    output logic [NCH*8-1:0] duty_o,
    output logic [7:0]       chen_o,
    output logic [NCH*8-1:0] tdly_o,
    output logic [NCH*8-1:0] trise_o,
    output logic [NCH*8-1:0] tfall_o
);

    typedef struct packed {
        logic [7:0]            ctrl;
        logic [7:0]            breath;
        logic [7:0]            mode;
        logic [7:0]            cur;
        logic [7:0]            chen_stg;
        logic [7:0]            chen_live;
        logic [NCH-1:0][7:0]   duty_stg;
        logic [NCH-1:0][7:0]   duty_live;
        logic [NCH-1:0][7:0]   tdly_stg;
        logic [NCH-1:0][7:0]   tdly_live;
        logic [NCH-1:0][7:0]   trise_stg;
        logic [NCH-1:0][7:0]   trise_live;
        logic [NCH-1:0][7:0]   tfall_stg;
        logic [NCH-1:0][7:0]   tfall_live;
    } bank_t;

    function automatic bank_t bank_defaults();
        bank_t b;
        b           = '0;
        b.ctrl      = CTRL_DEFAULT;
        b.chen_stg  = CHEN_DEFAULT;
        b.chen_live = CHEN_DEFAULT;
        return b;
    endfunction

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_i) begin
            if (addr_i == A_RESET) begin
                bank_d = bank_defaults();
            end else if (addr_i == A_UPD_LED) begin
                bank_d.duty_live = bank_q.duty_stg;
                bank_d.chen_live = bank_q.chen_stg;
            end else if (addr_i == A_UPD_TIME) begin
                bank_d.tdly_live  = bank_q.tdly_stg;
                bank_d.trise_live = bank_q.trise_stg;
                bank_d.tfall_live = bank_q.tfall_stg;
            end else begin
                case (addr_i)
                    A_CTRL:   bank_d.ctrl     = data_i;
                    A_BREATH: bank_d.breath   = data_i;
                    A_MODE:   bank_d.mode     = data_i;
                    A_CUR:    bank_d.cur      = data_i;
                    A_CHEN:   bank_d.chen_stg = data_i;
                    default:  ;
                endcase
                for (int i = 0; i < NCH; i++) begin
                    if (addr_i == A_DUTY0  + 8'(i)) bank_d.duty_stg[i]  = data_i;
                    if (addr_i == A_TDLY0  + 8'(i)) bank_d.tdly_stg[i]  = data_i;
                    if (addr_i == A_TRISE0 + 8'(i)) bank_d.trise_stg[i] = data_i;
                    if (addr_i == A_TFALL0 + 8'(i)) bank_d.tfall_stg[i] = data_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= bank_defaults();
        else        bank_q <= bank_d;
    end

    assign ctrl_o   = bank_q.ctrl;
    assign breath_o = bank_q.breath;
    assign mode_o   = bank_q.mode;
    assign cur_o    = bank_q.cur;
    assign duty_o   = bank_q.duty_live;
    assign chen_o   = bank_q.chen_live;
    assign tdly_o   = bank_q.tdly_live;
    assign trise_o  = bank_q.trise_live;
    assign tfall_o  = bank_q.tfall_live;

    // R4
    led_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_UPD_LED) |=>
            (duty_o == $past(bank_q.duty_stg) && chen_o == $past(bank_q.chen_stg)));

    // R4
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && (addr_i == A_UPD_LED || addr_i == A_RESET)) |=> $stable(duty_o));

    // R5
    time_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_UPD_TIME) |=>
            (tdly_o == $past(bank_q.tdly_stg) && tfall_o == $past(bank_q.tfall_stg)));

    // R6
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_RESET) |=>
            (ctrl_o == CTRL_DEFAULT && chen_o == CHEN_DEFAULT && duty_o == '0 && cur_o == 8'h00));

endmodule

// File: rtl/led_i2c_regfile.sv
module led_i2c_regfile
    import led_i2c_pkg::*;
#(
    parameter int NCH         = 3,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [SEL_W-1:0] addr_sel_i,
    output logic             sda_oe_o,
    output logic [7:0]       ctrl_o,
    output logic [7:0]       breath_o,
    output logic [7:0]       mode_o,
    output logic [7:0]       cur_o,
    output logic [NCH*8-1:0] duty_o,
    output logic [7:0]       chen_o,
    output logic [NCH*8-1:0] tdly_o,
    output logic [NCH*8-1:0] trise_o,
    output logic [NCH*8-1:0] tfall_o
);

    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_stb;
    logic [7:0] wr_addr, wr_data;

    i2c_line_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_write_engine #(
        .SEL_W(SEL_W)
    ) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .addr_sel_i (addr_sel_i),
        .sda_oe_o   (sda_oe_o),
        .wr_stb_o   (wr_stb),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    led_reg_bank #(
        .NCH(NCH)
    ) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_stb),
        .addr_i   (wr_addr),
        .data_i   (wr_data),
        .ctrl_o   (ctrl_o),
        .breath_o (breath_o),
        .mode_o   (mode_o),
        .cur_o    (cur_o),
        .duty_o   (duty_o),
        .chen_o   (chen_o),
        .tdly_o   (tdly_o),
        .trise_o  (trise_o),
        .tfall_o  (tfall_o)
    );

endmodule

// File: tb/test_led_i2c_regfile.sv
module test_led_i2c_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam logic [7:0] DEV_W = 8'hD4;   // sel = 2'b10
    localparam logic [7:0] NONE  = 8'hFF;
    localparam int NVEC = 10;

    // {register, data, commit register or FF, expected live value}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h00, 8'h20, NONE,  8'h20},   // R7
        {8'h01, 8'h35, NONE,  8'h35},   // R7
        {8'h02, 8'h20, NONE,  8'h20},   // R7
        {8'h03, 8'h0C, NONE,  8'h0C},   // R7
        {8'h04, 8'h80, NONE,  8'h00},   // R4 staged only
        {8'h05, 8'hC8, 8'h07, 8'hC8},   // R4
        {8'h1D, 8'h05, 8'h07, 8'h05},   // R4
        {8'h0A, 8'h30, NONE,  8'h00},   // R5 staged only
        {8'h11, 8'h5A, 8'h1C, 8'h5A},   // R5
        {8'h17, 8'hF2, 8'h1C, 8'hF2}    // R5
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] sel = 2'b10;
    logic sda_oe;
    logic sda_line;
    logic [7:0] ctrl, breath, mode, cur, chen;
    logic [23:0] duty, tdly, trise, tfall;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    led_i2c_regfile i_led_i2c_regfile (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel_i(sel), .sda_oe_o(sda_oe),
        .ctrl_o(ctrl), .breath_o(breath), .mode_o(mode), .cur_o(cur),
        .duty_o(duty), .chen_o(chen), .tdly_o(tdly), .trise_o(trise), .tfall_o(tfall)
    );

    function automatic logic [7:0] live_byte(input logic [7:0] a);
        case (a)
            8'h00: return ctrl;
            8'h01: return breath;
            8'h02: return mode;
            8'h03: return cur;
            8'h04: return duty[7:0];
            8'h05: return duty[15:8];
            8'h06: return duty[23:16];
            8'h1D: return chen;
            8'h0A: return tdly[7:0];
            8'h0B: return tdly[15:8];
            8'h0C: return tdly[23:16];
            8'h10: return trise[7:0];
            8'h11: return trise[15:8];
            8'h12: return trise[23:16];
            8'h16: return tfall[7:0];
            8'h17: return tfall[15:8];
            8'h18: return tfall[23:16];
            default: return 8'hxx;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(Q);
        scl_m = 1'b1; wclk(Q);
        sda_m = 1'b0; wclk(Q);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(Q);
        scl_m = 1'b1; wclk(Q);
        sda_m = 1'b1; wclk(Q);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b;    wclk(Q);
        scl_m = 1'b1; wclk(Q);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_m = 1'b1; wclk(Q);
        scl_m = 1'b1; wclk(Q/2);
        acked = (sda_line == 1'b0);
        wclk(Q/2);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic write_reg(input logic [7:0] r, input logic [7:0] d, input string req);
        logic a;
        bus_start();
        send_byte(DEV_W, a); check({req, " addr ack (R2)"}, a, 1);
        send_byte(r, a);     check({req, " ptr ack (R2)"}, a, 1);
        send_byte(d, a);     check({req, " data ack (R2)"}, a, 1);
        bus_stop();
        wclk(10);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        wclk(5);
        rst_n = 1'b1;
        wclk(5);

        // R6 reset state
        check("R6 ctrl default", ctrl, 8'h01);
        check("R6 chen default", chen, 8'h07);
        check("R6 duty default", duty, 24'h0);
        check("R6 timing default", {tdly, trise, tfall} == '0, 1);
        check("R9 idle release", sda_oe, 0);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            write_reg(VEC[v][31:24], VEC[v][23:16], "R4/R5/R7 vec");
            if (VEC[v][15:8] != NONE) write_reg(VEC[v][15:8], 8'h00, "commit");
            check($sformatf("R4/R5/R7 vec %0d", v), live_byte(VEC[v][31:24]), VEC[v][7:0]);
        end

        // R3 burst fills consecutive registers
        bus_start();
        send_byte(DEV_W, a); check("R3 addr ack", a, 1);
        send_byte(8'h04, a);
        send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
        check("R3 last data ack", a, 1);
        bus_stop(); wclk(10);
        check("R4 burst not yet live", duty[7:0], 8'h80);
        write_reg(8'h07, 8'h5E, "R4 commit");
        check("R3 burst duty", duty, 24'h332211);

        // R8 unmapped bytes acked and pointer advances
        bus_start();
        send_byte(DEV_W, a);
        send_byte(8'h08, a);
        send_byte(8'hAA, a); check("R8 unmapped ack", a, 1);
        send_byte(8'hBB, a); check("R8 unmapped ack 2", a, 1);
        send_byte(8'hCC, a);
        bus_stop(); wclk(10);
        write_reg(8'h1C, 8'h00, "R5 commit");
        check("R8 pointer advanced to 0Ah", tdly[7:0], 8'hCC);
        check("R8 duty untouched", duty, 24'h332211);

        // R1 wrong select bits
        bus_start();
        send_byte(8'hD0, a); check("R1 mismatch nack", a, 0);
        send_byte(8'h03, a); check("R1 ignored ptr nack", a, 0);
        send_byte(8'h55, a); check("R1 ignored data nack", a, 0);
        bus_stop(); wclk(10);
        check("R1 cur unchanged", cur, 8'h0C);
        // R1 read direction bit
        bus_start();
        send_byte(8'hD5, a); check("R1 read nack", a, 0);
        bus_stop(); wclk(10);
        // R1 other select value after pin change
        sel = 2'b01;
        bus_start();
        send_byte(8'hD2, a); check("R1 sel 01 ack", a, 1);
        bus_stop(); wclk(10);
        sel = 2'b10;

        // R9 START inside a byte restarts reception
        bus_start();
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_start();
        send_byte(DEV_W, a); check("R9 restart addr ack", a, 1);
        send_byte(8'h03, a);
        send_byte(8'h1C, a);
        bus_stop(); wclk(10);
        check("R9 write after restart", cur, 8'h1C);
        check("R9 released after stop", sda_oe, 0);

        // R6 soft reset register
        write_reg(8'h2F, 8'hA5, "R6 reset write");
        check("R6 ctrl after reset", ctrl, 8'h01);
        check("R6 chen after reset", chen, 8'h07);
        check("R6 duty after reset", duty, 24'h0);
        check("R6 cur after reset", cur, 8'h00);
        check("R6 tdly after reset", tdly, 24'h0);
        write_reg(8'h07, 8'h00, "R6 commit after reset");
        check("R6 staged duty cleared", duty, 24'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule